// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a 32-bit load/store integer processor built as a five-stage pipeline: fetch, decode with register read, execute, memory access and writeback. It runs a small fixed-length instruction set. The set has five register-to-register ALU operations, a word load, a word store and a branch taken when two registers are equal. Instruction storage and data storage are two separate word arrays inside the core, so a memory-stage access never competes with fetch. Both arrays are filled through a preload port while the core is held in reset.

Each stage's control bits are decoded once, in decode, and travel with the instruction through the pipeline registers together with its destination register number. Values produced by the ALU are forwarded to the execute operands and to the decode-stage branch comparator. A load whose result is needed at once costs a single bubble. Branches are compared and resolved in decode. Fetch always assumes the branch is not taken, and a taken branch discards the one instruction fetched behind it.

Two streams leave the core, and both are valid-only. The retire stream reports each register write. The store stream reports each data-memory write. Neither stream accepts back-pressure: a consumer must accept a beat in every cycle in which valid is high.

Top module: `core_pipe`

## Requirements
- R1: Field layout: opcode in bits 31:26, rs in bits 25:21, rt in bits 20:16, rd in bits 15:11, function in bits 5:0, and a signed 16-bit immediate in bits 15:0. Opcode 0 is an ALU operation rd = rs op rt, where function 0 is add, 1 is subtract, 2 is AND, 3 is OR and 4 is signed set-less-than.
- R2: Opcode 1 loads rt from the data word at byte address rs+imm. Opcode 2 stores rt to that address. A store shows on the store stream in its memory-stage cycle, two cycles after its decode cycle.
- R3: Register 0 always reads as zero. A write to it is dropped, never shows on the retire stream, and is never forwarded.
- R4: An instruction that reads an ALU result from one of the two instructions just before it gets that value by forwarding, with no stall. A register-writing instruction retires three cycles after its decode cycle.
- R5: When both later stages hold a write to the same source register, the value from the newer instruction wins.
- R6: A load followed at once by an instruction that reads the loaded register as an ALU, address or store-data operand delays that instruction by exactly one cycle.
- R7: Opcode 3 is taken when rs equals rt, with the target at the next sequential address plus imm times 4. Not-taken costs no cycle. Taken costs exactly one squashed slot, and that instruction has no effect.
- R8: A branch waits one cycle when an operand comes from the ALU instruction just before it, two cycles when it comes from a load just before it, and one cycle when it comes from a load two instructions before it.
- R9: A register written in the writeback stage is seen by a decode-stage read in the same cycle.
- R10: While rst_n is low, pre_we writes pre_data to word pre_addr of the instruction array when pre_dmem is 0, and of the data array when pre_dmem is 1.
- R11: During reset neither stream is valid. After reset, fetch starts at address 0 with all registers zero, and the first instruction is in decode in the cycle after the first rising edge.
- R12: Any other opcode, and an ALU function above 4, behaves as a no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_we | input | 1 | Preload write strobe |
| pre_dmem | input | 1 | Preload target: 0 instruction array, 1 data array |
| pre_addr | input | 6 | Preload word index |
| pre_data | input | 32 | Preload word |
| ret_valid | output | 1 | A register write retires this cycle |
| ret_reg | output | 5 | Retiring destination register |
| ret_data | output | 32 | Retiring value |
| st_valid | output | 1 | A store writes data memory this cycle |
| st_addr | output | 32 | Store byte address |
| st_data | output | 32 | Store data |

## Verification
The first program chains loads and ALU operations. It separates results that come over the one-stage bypass from those over the two-stage bypass. It also shows which of two pending writes wins, whether the load-use bubble is inserted for both operands and for store data, and whether register 0, unknown encodings and same-cycle write-through behave correctly. The second program runs a down-counting loop and a set of branches that depend on an ALU result or a load one or two instructions back, with both taken and not-taken outcomes. The retire and store cycle of every instruction therefore measures each stall and squash separately. Every retire and store beat is compared against a behavioural interpreter. That interpreter predicts the cycle of each beat from the decode time, so an extra or missing stall, a skipped squash or a wrong forwarded value all show up as a mismatch.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int XLEN = 32;
  localparam int REGS = 32;
  localparam int RAW  = $clog2(REGS);

  localparam logic [5:0] OP_ALU   = 6'd0;
  localparam logic [5:0] OP_LOAD  = 6'd1;
  localparam logic [5:0] OP_STORE = 6'd2;
  localparam logic [5:0] OP_BEQ   = 6'd3;

  typedef enum logic [2:0] {
    FN_ADD = 3'd0, FN_SUB = 3'd1, FN_AND = 3'd2, FN_OR = 3'd3, FN_SLT = 3'd4
  } alu_fn_e;

  typedef enum logic [1:0] { FW_NONE, FW_EXMEM, FW_MEMWB } fwd_e;

  typedef struct packed {
    logic    reg_we;
    logic    mem_rd;
    logic    mem_we;
    logic    use_imm;
    alu_fn_e fn;
  } ctrl_t;

  typedef struct packed {
    ctrl_t           c;
    logic [RAW-1:0]  rs;
    logic [RAW-1:0]  rt;
    logic [RAW-1:0]  dst;
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] b;
    logic [XLEN-1:0] imm;
  } idex_t;

  typedef struct packed {
    ctrl_t           c;
    logic [RAW-1:0]  dst;
    logic [XLEN-1:0] alu;
    logic [XLEN-1:0] sdata;
  } exmem_t;

  typedef struct packed {
    logic            reg_we;
    logic [RAW-1:0]  dst;
    logic [XLEN-1:0] val;
  } memwb_t;
endpackage

// File: rtl/core_regfile.sv
module core_regfile import core_pkg::*; #(
  parameter int NREG = REGS,
  parameter int W    = XLEN
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NREG)-1:0] ra1,
  input  logic [$clog2(NREG)-1:0] ra2,
  output logic [W-1:0]            rd1,
  output logic [W-1:0]            rd2,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wa,
  input  logic [W-1:0]            wd
);
  localparam int AW = $clog2(NREG);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  // same-cycle write is visible to the reader
  function automatic logic [W-1:0] rd_port(input logic [AW-1:0] a);
    if (a == '0)                return '0;
    else if (we && wa == a)     return wd;
    else                        return regs[a];
  endfunction

  always_comb begin
    rd1 = rd_port(ra1);
    rd2 = rd_port(ra2);
  end
endmodule

// File: rtl/core_alu.sv
module core_alu import core_pkg::*; #(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (fn)
      FN_SUB:  y = a - b;
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/core_hazard.sv
module core_hazard import core_pkg::*; (
  input  logic [RAW-1:0] id_rs,
  input  logic [RAW-1:0] id_rt,
  input  logic           id_use_rs,
  input  logic           id_use_rt,
  input  logic           id_branch,
  input  logic           ex_we,
  input  logic           ex_load,
  input  logic [RAW-1:0] ex_dst,
  input  logic [RAW-1:0] ex_rs,
  input  logic [RAW-1:0] ex_rt,
  input  logic           mem_we,
  input  logic           mem_load,
  input  logic [RAW-1:0] mem_dst,
  input  logic           wb_we,
  input  logic [RAW-1:0] wb_dst,
  output logic           stall,
  output fwd_e           fwd_a,
  output fwd_e           fwd_b,
  output logic           br_fwd_a,
  output logic           br_fwd_b
);
  function automatic logic hit(input logic we, input logic [RAW-1:0] dst,
                               input logic [RAW-1:0] src, input logic use_it);
    return use_it && we && dst != '0 && dst == src;
  endfunction

  logic ex_hit_any, mem_hit_any;
  always_comb begin
    ex_hit_any  = hit(ex_we, ex_dst, id_rs, id_use_rs) || hit(ex_we, ex_dst, id_rt, id_use_rt);
    mem_hit_any = hit(mem_we, mem_dst, id_rs, id_use_rs) || hit(mem_we, mem_dst, id_rt, id_use_rt);
    stall = (ex_load && ex_hit_any) ||
            (id_branch && ex_hit_any) ||
            (id_branch && mem_load && mem_hit_any);

    // newer producer (memory stage) ahead of older (writeback stage)
    if (hit(mem_we, mem_dst, ex_rs, 1'b1))     fwd_a = FW_EXMEM;
    else if (hit(wb_we, wb_dst, ex_rs, 1'b1))  fwd_a = FW_MEMWB;
    else                                       fwd_a = FW_NONE;
    if (hit(mem_we, mem_dst, ex_rt, 1'b1))     fwd_b = FW_EXMEM;
    else if (hit(wb_we, wb_dst, ex_rt, 1'b1))  fwd_b = FW_MEMWB;
    else                                       fwd_b = FW_NONE;

    br_fwd_a = !mem_load && hit(mem_we, mem_dst, id_rs, 1'b1);
    br_fwd_b = !mem_load && hit(mem_we, mem_dst, id_rt, 1'b1);
  end
endmodule

// File: rtl/core_pipe.sv
module core_pipe import core_pkg::*; #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int PAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pre_we,
  input  logic            pre_dmem,
  input  logic [PAW-1:0]  pre_addr,
  input  logic [XLEN-1:0] pre_data,
  output logic            ret_valid,
  output logic [RAW-1:0]  ret_reg,
  output logic [XLEN-1:0] ret_data,
  output logic            st_valid,
  output logic [XLEN-1:0] st_addr,
  output logic [XLEN-1:0] st_data
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pc, ifid_instr, ifid_pc4;
  idex_t  idex;
  exmem_t exmem;
  memwb_t memwb;

  // ---------------- decode ----------------
  logic [5:0]      op, fn6;
  logic [RAW-1:0]  rs, rt, rd, dst;
  logic [XLEN-1:0] imm, rf_a, rf_b, br_a, br_b, br_target, wb_val;
  logic            use_rs, use_rt, is_br, stall, br_take, br_fwd_a, br_fwd_b, wb_we;
  ctrl_t           dc;
  fwd_e            fwd_a, fwd_b;

  assign op  = ifid_instr[31:26];
  assign rs  = ifid_instr[25:21];
  assign rt  = ifid_instr[20:16];
  assign rd  = ifid_instr[15:11];
  assign fn6 = ifid_instr[5:0];
  assign imm = {{(XLEN-16){ifid_instr[15]}}, ifid_instr[15:0]};

  always_comb begin
    dc = '0; use_rs = 1'b0; use_rt = 1'b0; is_br = 1'b0; dst = rd;
    case (op)
      OP_ALU: if (fn6 <= 6'd4) begin
        dc.reg_we = 1'b1; dc.fn = alu_fn_e'(fn6[2:0]); use_rs = 1'b1; use_rt = 1'b1;
      end
      OP_LOAD: begin
        dc.reg_we = 1'b1; dc.mem_rd = 1'b1; dc.use_imm = 1'b1; use_rs = 1'b1; dst = rt;
      end
      OP_STORE: begin
        dc.mem_we = 1'b1; dc.use_imm = 1'b1; use_rs = 1'b1; use_rt = 1'b1;
      end
      OP_BEQ: begin
        is_br = 1'b1; use_rs = 1'b1; use_rt = 1'b1;
      end
      default: ;
    endcase
  end

  core_regfile #(.NREG(REGS), .W(XLEN)) u_rf (
    .clk(clk), .rst_n(rst_n), .ra1(rs), .ra2(rt), .rd1(rf_a), .rd2(rf_b),
    .we(wb_we), .wa(memwb.dst), .wd(wb_val)
  );

  core_hazard u_hz (
    .id_rs(rs), .id_rt(rt), .id_use_rs(use_rs), .id_use_rt(use_rt), .id_branch(is_br),
    .ex_we(idex.c.reg_we), .ex_load(idex.c.mem_rd), .ex_dst(idex.dst),
    .ex_rs(idex.rs), .ex_rt(idex.rt),
    .mem_we(exmem.c.reg_we), .mem_load(exmem.c.mem_rd), .mem_dst(exmem.dst),
    .wb_we(wb_we), .wb_dst(memwb.dst),
    .stall(stall), .fwd_a(fwd_a), .fwd_b(fwd_b), .br_fwd_a(br_fwd_a), .br_fwd_b(br_fwd_b)
  );

  assign br_a      = br_fwd_a ? exmem.alu : rf_a;
  assign br_b      = br_fwd_b ? exmem.alu : rf_b;
  assign br_take   = is_br && (br_a == br_b) && !stall;
  assign br_target = ifid_pc4 + {imm[XLEN-3:0], 2'b00};

  // ---------------- execute ----------------
  logic [XLEN-1:0] op_a, op_b, alu_b, alu_y;
  always_comb begin
    case (fwd_a)
      FW_EXMEM: op_a = exmem.alu;
      FW_MEMWB: op_a = wb_val;
      default:  op_a = idex.a;
    endcase
    case (fwd_b)
      FW_EXMEM: op_b = exmem.alu;
      FW_MEMWB: op_b = wb_val;
      default:  op_b = idex.b;
    endcase
    alu_b = idex.c.use_imm ? idex.imm : op_b;
  end

  core_alu #(.W(XLEN)) u_alu (.a(op_a), .b(alu_b), .fn(idex.c.fn), .y(alu_y));

  // ---------------- pipeline registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; ifid_instr <= '0; ifid_pc4 <= '0;
      idex <= '0; exmem <= '0; memwb <= '0;
    end else begin
      if (!stall) pc <= br_take ? br_target : pc + XLEN'(4);
      if (br_take) begin
        ifid_instr <= '0; ifid_pc4 <= '0;
      end else if (!stall) begin
        ifid_instr <= imem[pc[IAW+1:2]]; ifid_pc4 <= pc + XLEN'(4);
      end
      if (stall) idex <= '0;
      else begin
        idex.c   <= dc;
        idex.rs  <= use_rs ? rs : '0;
        idex.rt  <= use_rt ? rt : '0;
        idex.dst <= dst;
        idex.a   <= rf_a;
        idex.b   <= rf_b;
        idex.imm <= imm;
      end
      exmem.c     <= idex.c;
      exmem.dst   <= idex.dst;
      exmem.alu   <= alu_y;
      exmem.sdata <= op_b;
      memwb.reg_we <= exmem.c.reg_we;
      memwb.dst    <= exmem.dst;
      memwb.val    <= exmem.c.mem_rd ? dmem[exmem.alu[DAW+1:2]] : exmem.alu;
    end
  end

  // ---------------- storage ----------------
  always_ff @(posedge clk) begin
    if (pre_we && !pre_dmem) imem[pre_addr[IAW-1:0]] <= pre_data;
  end

  always_ff @(posedge clk) begin
    if (pre_we && pre_dmem)   dmem[pre_addr[DAW-1:0]] <= pre_data;
    else if (exmem.c.mem_we)  dmem[exmem.alu[DAW+1:2]] <= exmem.sdata;
  end

  // ---------------- writeback / streams ----------------
  assign wb_val    = memwb.val;
  assign wb_we     = memwb.reg_we && memwb.dst != '0;
  assign ret_valid = wb_we;
  assign ret_reg   = memwb.dst;
  assign ret_data  = memwb.val;
  assign st_valid  = exmem.c.mem_we;
  assign st_addr   = exmem.alu;
  assign st_data   = exmem.sdata;

  logic unused_bits;
  assign unused_bits = ^{pc[XLEN-1:IAW+2], pc[1:0], ifid_instr[10:6]};
endmodule

// File: rtl/core_pipe_chk.sv
module core_pipe_chk import core_pkg::*; (
  input logic            clk,
  input logic            rst_n,
  input logic            stall,
  input logic            br_take,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] br_target,
  input logic [XLEN-1:0] ifid_instr,
  input logic            idex_reg_we,
  input logic            idex_mem_we,
  input logic [RAW-1:0]  idex_rs,
  input logic [RAW-1:0]  idex_rt,
  input logic            mem_load,
  input logic [RAW-1:0]  mem_dst
);
  assert_stall_holds_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> pc == $past(pc));

  assert_stall_holds_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ifid_instr == $past(ifid_instr));

  assert_stall_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !idex_reg_we && !idex_mem_we);

  assert_load_never_raw_in_ex_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_load && mem_dst != '0 && (mem_dst == idex_rs || mem_dst == idex_rt)));

  assert_squash_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    br_take |=> ifid_instr == '0);

  assert_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    br_take |=> pc == $past(br_target));
endmodule

bind core_pipe core_pipe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .br_take(br_take), .pc(pc),
  .br_target(br_target), .ifid_instr(ifid_instr),
  .idex_reg_we(idex.c.reg_we), .idex_mem_we(idex.c.mem_we),
  .idex_rs(idex.rs), .idex_rt(idex.rt),
  .mem_load(exmem.c.mem_rd), .mem_dst(exmem.dst)
);

// File: tb/tb_core_pipe.sv
`timescale 1ns/1ps
module tb_core_pipe;
  logic        clk = 1'b0, rst_n = 1'b0, pre_we = 1'b0, pre_dmem = 1'b0;
  logic [5:0]  pre_addr = '0;
  logic [31:0] pre_data = '0;
  logic        ret_valid, st_valid;
  logic [4:0]  ret_reg;
  logic [31:0] ret_data, st_addr, st_data;

  core_pipe dut (
    .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .pre_dmem(pre_dmem),
    .pre_addr(pre_addr), .pre_data(pre_data),
    .ret_valid(ret_valid), .ret_reg(ret_reg), .ret_data(ret_data),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data)
  );

  always #2.5 clk = ~clk;

  typedef struct { int cyc; int r; logic [31:0] d; string tag; } ev_t;
  ev_t wbq[$];
  ev_t stq[$];

  logic [31:0] prog [64];
  logic [31:0] dinit [64];
  string       ptag [64];
  int          plen, last_cyc;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] f_alu(int fn, int rd, int rs, int rt);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
  endfunction
  function automatic logic [31:0] f_mem(int op, int rt, int rs, int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) begin
      prog[i] = 32'h0; ptag[i] = "R1"; dinit[i] = 32'(i * 3);
    end
  endtask

  // behavioural interpreter with decode-time bookkeeping
  task automatic model();
    logic [31:0] rg [32];
    logic [31:0] dm [64];
    int rdy_id [32];
    int rdy_ex [32];
    int t = 1, pc = 0, steps = 0;
    wbq.delete(); stq.delete();
    for (int i = 0; i < 32; i++) begin rg[i] = 0; rdy_id[i] = 0; rdy_ex[i] = 0; end
    for (int i = 0; i < 64; i++) dm[i] = dinit[i];
    while (pc / 4 < plen && steps < 400) begin
      logic [31:0] w, sim, v, addr;
      int op, rs, rt, rd, fn;
      bit u_rs, u_rt, br;
      w = prog[pc / 4];
      op = int'(w[31:26]); rs = int'(w[25:21]); rt = int'(w[20:16]);
      rd = int'(w[15:11]); fn = int'(w[5:0]);
      sim = {{16{w[15]}}, w[15:0]};
      br = (op == 3);
      u_rs = (op <= 3);
      u_rt = (op == 0 || op == 2 || op == 3);
      if (u_rs && rs != 0) t = br ? ((rdy_id[rs] > t) ? rdy_id[rs] : t) : ((rdy_ex[rs] > t) ? rdy_ex[rs] : t);
      if (u_rt && rt != 0) t = br ? ((rdy_id[rt] > t) ? rdy_id[rt] : t) : ((rdy_ex[rt] > t) ? rdy_ex[rt] : t);
      pc += 4;
      case (op)
        0: if (fn <= 4) begin
          case (fn)
            0: v = rg[rs] + rg[rt];
            1: v = rg[rs] - rg[rt];
            2: v = rg[rs] & rg[rt];
            3: v = rg[rs] | rg[rt];
            default: v = ($signed(rg[rs]) < $signed(rg[rt])) ? 32'd1 : 32'd0;
          endcase
          if (rd != 0) begin
            rg[rd] = v; rdy_ex[rd] = t + 1; rdy_id[rd] = t + 2;
            wbq.push_back('{t + 3, rd, v, ptag[(pc - 4) / 4]});
          end
        end
        1: begin
          addr = rg[rs] + sim; v = dm[addr[7:2]];
          if (rt != 0) begin
            rg[rt] = v; rdy_ex[rt] = t + 2; rdy_id[rt] = t + 3;
            wbq.push_back('{t + 3, rt, v, ptag[(pc - 4) / 4]});
          end
        end
        2: begin
          addr = rg[rs] + sim; dm[addr[7:2]] = rg[rt];
          stq.push_back('{t + 2, int'(addr), rg[rt], ptag[(pc - 4) / 4]});
        end
        3: if (rg[rs] == rg[rt]) begin
          pc = pc + int'(sim) * 4; t = t + 1;
        end
        default: ;
      endcase
      t = t + 1;
      steps++;
    end
    last_cyc = t + 3;
  endtask

  task automatic preload();
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      pre_we = 1'b1; pre_dmem = (i >= 64); pre_addr = 6'(i % 64);
      pre_data = (i >= 64) ? dinit[i - 64] : prog[i];
    end
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic run_prog();
    int cyc = 0;
    rst_n = 1'b0;
    preload();
    model();
    @(negedge clk);
    check(!ret_valid && !st_valid, "R11", "streams idle in reset",
          {30'd0, ret_valid, st_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (last_cyc + 6) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (ret_valid) begin
        if (wbq.size() > 0) begin
          ev_t e = wbq.pop_front();
          check(e.cyc == cyc && e.r == int'(ret_reg), e.tag, "retire cycle/reg",
                32'(cyc * 256 + int'(ret_reg)), 32'(e.cyc * 256 + e.r));
          check(e.d == ret_data, e.tag, "retire data", ret_data, e.d);
        end else check(1'b0, "R7 or R12", "unexpected retire", 32'(ret_reg), 32'd0);
      end else if (wbq.size() > 0 && wbq[0].cyc <= cyc) begin
        ev_t e = wbq.pop_front();
        check(1'b0, e.tag, "missing retire", 32'(cyc), 32'(e.cyc));
      end
      if (st_valid) begin
        if (stq.size() > 0) begin
          ev_t e = stq.pop_front();
          check(e.cyc == cyc && e.r == int'(st_addr), e.tag, "store cycle/addr",
                32'(cyc * 256) + st_addr, 32'(e.cyc * 256 + e.r));
          check(e.d == st_data, e.tag, "store data", st_data, e.d);
        end else check(1'b0, "R2", "unexpected store", st_addr, 32'd0);
      end else if (stq.size() > 0 && stq[0].cyc <= cyc) begin
        ev_t e = stq.pop_front();
        check(1'b0, e.tag, "missing store", 32'(cyc), 32'(e.cyc));
      end
    end
    check(wbq.size() == 0 && stq.size() == 0, "R4", "all events seen",
          32'(wbq.size() + stq.size()), 32'd0);
  endtask

  initial begin
    // program 1: ALU, loads/stores, forwarding, interlock, r0, unknown codes
    clear_prog();
    dinit[0] = 32'd7; dinit[1] = 32'd12; dinit[2] = 32'hFFFF_FFF0;
    prog[0]  = f_mem(1, 1, 0, 0);   ptag[0]  = "R10";
    prog[1]  = f_mem(1, 2, 0, 4);   ptag[1]  = "R10";
    prog[2]  = f_alu(0, 3, 1, 2);   ptag[2]  = "R6";
    prog[3]  = f_alu(1, 4, 3, 1);   ptag[3]  = "R4";
    prog[4]  = f_alu(2, 5, 3, 4);   ptag[4]  = "R4";
    prog[5]  = f_alu(3, 5, 5, 1);   ptag[5]  = "R1";
    prog[6]  = f_alu(0, 6, 1, 1);   ptag[6]  = "R1";
    prog[7]  = f_alu(0, 6, 6, 2);   ptag[7]  = "R4";
    prog[8]  = f_alu(0, 7, 6, 6);   ptag[8]  = "R5";
    prog[9]  = f_mem(1, 8, 0, 8);   ptag[9]  = "R2";
    prog[10] = f_alu(4, 9, 8, 1);   ptag[10] = "R6";
    prog[11] = f_alu(4, 10, 1, 8);  ptag[11] = "R1";
    prog[12] = f_mem(2, 7, 0, 16);  ptag[12] = "R2";
    prog[13] = f_mem(1, 11, 0, 16); ptag[13] = "R2";
    prog[14] = f_mem(2, 11, 0, 20); ptag[14] = "R6";
    prog[15] = f_alu(0, 0, 1, 2);   ptag[15] = "R3";
    prog[16] = f_alu(0, 12, 0, 1);  ptag[16] = "R3";
    prog[17] = {6'd9, 5'd1, 5'd13, 5'd13, 11'd0}; ptag[17] = "R12";
    prog[18] = f_alu(7, 13, 1, 2);  ptag[18] = "R12";
    prog[19] = f_alu(3, 14, 13, 3); ptag[19] = "R12";
    prog[20] = f_alu(2, 16, 1, 2);  ptag[20] = "R1";
    prog[21] = f_alu(1, 17, 2, 1);  ptag[21] = "R1";
    prog[22] = f_alu(0, 15, 14, 1); ptag[22] = "R9";
    plen = 23;
    run_prog();

    // program 2: branches, loop, squash and branch-operand stalls
    clear_prog();
    dinit[0] = 32'd3; dinit[1] = 32'd1; dinit[2] = 32'd0; dinit[3] = 32'd3;
    prog[0]  = f_mem(1, 1, 0, 0);    ptag[0]  = "R10";
    prog[1]  = f_mem(1, 2, 0, 4);    ptag[1]  = "R10";
    prog[2]  = f_mem(1, 3, 0, 8);    ptag[2]  = "R2";
    prog[3]  = f_alu(1, 1, 1, 2);    ptag[3]  = "R8";
    prog[4]  = f_mem(3, 3, 1, 2);    ptag[4]  = "R8";
    prog[5]  = f_mem(3, 0, 0, -3);   ptag[5]  = "R7";
    prog[6]  = f_alu(0, 9, 2, 2);    ptag[6]  = "R7";
    prog[7]  = f_alu(0, 4, 1, 2);    ptag[7]  = "R7";
    prog[8]  = f_mem(1, 5, 0, 12);   ptag[8]  = "R2";
    prog[9]  = f_mem(3, 4, 5, 1);    ptag[9]  = "R8";
    prog[10] = f_alu(0, 6, 5, 5);    ptag[10] = "R8";
    prog[11] = f_mem(1, 7, 0, 0);    ptag[11] = "R2";
    prog[12] = f_alu(3, 8, 0, 0);    ptag[12] = "R3";
    prog[13] = f_mem(3, 5, 7, 1);    ptag[13] = "R8";
    prog[14] = f_alu(0, 10, 1, 2);   ptag[14] = "R7";
    prog[15] = f_alu(1, 11, 7, 2);   ptag[15] = "R8";
    prog[16] = f_mem(3, 11, 11, 1);  ptag[16] = "R8";
    prog[17] = f_alu(0, 12, 2, 2);   ptag[17] = "R7";
    prog[18] = f_alu(0, 13, 11, 11); ptag[18] = "R8";
    prog[19] = f_mem(2, 13, 3, 32);  ptag[19] = "R2";
    prog[20] = f_mem(3, 0, 0, 0);    ptag[20] = "R7";
    prog[21] = f_alu(0, 14, 2, 2);   ptag[21] = "R7";
    plen = 22;
    run_prog();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog expired: actual %h expected %h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule